// File: doc/BRIEF.md
# Shared System Bus Arbiter

This block gives one local processor orderly access to a system bus that several masters share. It watches the processor's status code to see when a cycle needs the shared bus. It then asks for the bus with an active-low request and waits for two things: a priority grant on its priority input, and a free busy line. Once both hold, it takes the bus. It pulls the open-drain busy line low and enables the processor's address path. While it is neither asking for nor holding the bus, it passes priority down a daisy chain to the arbiters below it.

An arbiter that owns the bus keeps it until a surrender condition arises and the processor is at a point where letting go is safe. Two events can cause a surrender: losing priority to a higher arbiter, or a lower arbiter pulling the shared common-request line. A processor lock blocks every surrender. A separate common-request lock blocks only surrender to common-request requesters. Three straps choose which cycles need the bus and how freely it is handed on: one takes an address-map input into account, one lets I/O cycles run without the bus, and one hands the bus to any requester at each cycle end. The bus-side inputs pass through synchronizer chains before the state machine uses them.

Top module: `mba_arbiter`

## Requirements
- R1: While `rst_n` is low, and from the clock edge after `init_n` is sampled low, the block does not hold the bus: `breq_n`=1, `aen_n`=1, `cbrq_drive`=0, and `busy_drive` is 0 once any release step has finished.
- R2: Status codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. When the block is idle and a status that needs the bus is seen, `breq_n` goes low. With no strap set, every code except 011 and 111 needs the bus.
- R3: The bus is taken only after the synchronized priority input is low and the synchronized busy line is high. While the bus is held, `busy_drive`=1, `breq_n`=0 and `aen_n`=0.
- R4: While requesting and not yet holding the bus, `cbrq_drive`=1. The holder never drives `cbrq_drive`.
- R5: `prio_out_n` is low only when `prio_in_n` is low and the block neither requests nor holds the bus.
- R6: A holder whose synchronized priority input is high surrenders once the current status needs no bus.
- R7: While `lock_n` is low, a holder never surrenders.
- R8: While `crqlck_n` is low, a common-request line pulled low causes no surrender. Loss of priority still does.
- R9: A common request with `cbrq_in_n` low causes surrender as follows. With `anyrq_strap`=1, surrender happens at any status that needs no bus, including passive (111). With `anyrq_strap`=0, it happens only at a non-passive status that needs no bus, such as halt.
- R10: With `resb_strap`=1, a cycle needs the bus only while `sysmap` is high. With `resb_strap`=0, `sysmap` has no effect.
- R11: With `iob_strap`=1, only memory and fetch codes (1xx except 111) need the bus. I/O and interrupt-acknowledge codes do not.
- R12: On surrender or init from ownership, `aen_n` and `breq_n` go high one clock before `busy_drive` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Active-low bus-wide initialise, sampled on the clock |
| stat | input | 3 | Processor status code |
| lock_n | input | 1 | Active-low processor lock, blocks all surrender |
| crqlck_n | input | 1 | Active-low lock against common-request surrender |
| resb_strap | input | 1 | Address-map mode strap |
| iob_strap | input | 1 | I/O-on-local-bus mode strap |
| anyrq_strap | input | 1 | Surrender-to-any-requester strap |
| sysmap | input | 1 | Address-map decode: high means the cycle targets the shared bus |
| prio_in_n | input | 1 | Active-low priority grant from the chain above |
| busy_in_n | input | 1 | Sensed level of the shared busy line |
| cbrq_in_n | input | 1 | Sensed level of the shared common-request line |
| breq_n | output | 1 | Active-low bus request |
| prio_out_n | output | 1 | Active-low priority to the next lower arbiter |
| busy_drive | output | 1 | 1 pulls the busy line low |
| cbrq_drive | output | 1 | 1 pulls the common-request line low |
| aen_n | output | 1 | Active-low address enable to the local bus controller |

## Verification
Ownership is first tried with every status code under all strap and address-map combinations, which separates the I/O, address-map and plain modes by whether the bus is taken at all. From ownership, the block then faces random mixes of a new status, lost priority, common request, lock and common-request lock. Each outcome tells apart which surrender source won and which lock stopped it. Directed cases pin down a busy line held by another master, the exact release order, init during ownership, and the window where common request without the any-request strap waits for a halt.

// File: rtl/mba_pkg.sv
package mba_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } arb_state_e;

  localparam logic [2:0] STS_INTA    = 3'b000;
  localparam logic [2:0] STS_HALT    = 3'b011;
  localparam logic [2:0] STS_PASSIVE = 3'b111;
endpackage

// File: rtl/mba_sync.sv
module mba_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {N{RST_VAL}};
    else        chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/mba_decode.sv
module mba_decode
  import mba_pkg::*;
(
  input  logic [2:0] stat_q,
  input  logic       iob_strap,
  input  logic       resb_strap,
  input  logic       sysmap,
  output logic       need,
  output logic       quiet
);
  logic passive, halt, mem_cyc, io_cyc, mapped;

  always_comb begin
    passive = (stat_q == STS_PASSIVE);
    halt    = (stat_q == STS_HALT);
    mem_cyc = stat_q[2] && !passive;
    io_cyc  = !stat_q[2] && !halt;
    mapped  = !resb_strap || sysmap;
    need    = (iob_strap ? mem_cyc : (mem_cyc || io_cyc)) && mapped;
    quiet   = !passive && !need;
  end
endmodule

// File: rtl/mba_fsm.sv
module mba_fsm
  import mba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_n,
  input  logic       need,
  input  logic       quiet,
  input  logic       prio_s,
  input  logic       busy_s,
  input  logic       cbrq_s,
  input  logic       lock_n,
  input  logic       crqlck_n,
  input  logic       anyrq_strap,
  output arb_state_e state
);
  arb_state_e state_nx;
  logic surr_prio, surr_cbrq, surrender, grant;

  always_comb begin
    grant     = !prio_s && busy_s;
    surr_prio = prio_s && !need;
    surr_cbrq = !cbrq_s && crqlck_n && (anyrq_strap ? !need : quiet);
    surrender = lock_n && (surr_prio || surr_cbrq);
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (init_n && need)      state_nx = ST_REQ;
      ST_REQ:  if (!init_n)             state_nx = ST_IDLE;
               else if (grant)          state_nx = ST_OWN;
      ST_OWN:  if (!init_n || surrender) state_nx = ST_REL;
      ST_REL:                           state_nx = ST_IDLE;
      default:                          state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/mba_arbiter.sv
module mba_arbiter
  import mba_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_n,
  input  logic [2:0] stat,
  input  logic       lock_n,
  input  logic       crqlck_n,
  input  logic       resb_strap,
  input  logic       iob_strap,
  input  logic       anyrq_strap,
  input  logic       sysmap,
  input  logic       prio_in_n,
  input  logic       busy_in_n,
  input  logic       cbrq_in_n,
  output logic       breq_n,
  output logic       prio_out_n,
  output logic       busy_drive,
  output logic       cbrq_drive,
  output logic       aen_n
);
  logic [2:0] stat_q;
  logic       stat_en;
  logic       prio_s, busy_s, cbrq_s;
  logic       need, quiet;
  arb_state_e state;

  assign stat_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STS_PASSIVE;
    else if (stat_en) stat_q <= stat;
  end

  mba_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_prio (
    .clk(clk), .rst_n(rst_n), .d(prio_in_n), .q(prio_s));
  mba_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_busy (
    .clk(clk), .rst_n(rst_n), .d(busy_in_n), .q(busy_s));
  mba_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cbrq (
    .clk(clk), .rst_n(rst_n), .d(cbrq_in_n), .q(cbrq_s));

  mba_decode u_decode (
    .stat_q(stat_q), .iob_strap(iob_strap), .resb_strap(resb_strap),
    .sysmap(sysmap), .need(need), .quiet(quiet));

  mba_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .need(need), .quiet(quiet),
    .prio_s(prio_s), .busy_s(busy_s), .cbrq_s(cbrq_s), .lock_n(lock_n),
    .crqlck_n(crqlck_n), .anyrq_strap(anyrq_strap), .state(state));

  always_comb begin
    breq_n     = !((state == ST_REQ) || (state == ST_OWN));
    busy_drive = (state == ST_OWN) || (state == ST_REL);
    aen_n      = (state != ST_OWN);
    cbrq_drive = (state == ST_REQ);
    prio_out_n = prio_in_n || (state != ST_IDLE);
  end
endmodule

// File: rtl/mba_arbiter_chk.sv
module mba_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic init_n,
  input logic lock_n,
  input logic prio_in_n,
  input logic prio_s,
  input logic busy_s,
  input logic breq_n,
  input logic aen_n,
  input logic busy_drive,
  input logic cbrq_drive,
  input logic prio_out_n
);
  assert_init_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> (breq_n && aen_n && !cbrq_drive));

  assert_grant_before_seize_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_drive) |-> $past(!prio_s && busy_s));

  assert_owner_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !aen_n |-> (busy_drive && !breq_n));

  assert_holder_no_cbrq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cbrq_drive |-> (!busy_drive && !breq_n));

  assert_chain_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_out_n |-> (!prio_in_n && breq_n && !busy_drive));

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!aen_n && !lock_n && init_n) |=> !aen_n);

  assert_aen_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen_n) |-> (busy_drive && breq_n));

  assert_busy_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_drive) |-> $past(aen_n));
endmodule

bind mba_arbiter mba_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_n(init_n), .lock_n(lock_n),
  .prio_in_n(prio_in_n), .prio_s(prio_s), .busy_s(busy_s), .breq_n(breq_n),
  .aen_n(aen_n), .busy_drive(busy_drive), .cbrq_drive(cbrq_drive),
  .prio_out_n(prio_out_n));

// File: tb/tb_mba_arbiter.sv
`timescale 1ns/1ps
module tb_mba_arbiter;
  logic       clk = 1'b0;
  logic       rst_n, init_n, lock_n, crqlck_n;
  logic       resb_strap, iob_strap, anyrq_strap, sysmap;
  logic [2:0] stat;
  logic       prio_in_n, busy_in_n, cbrq_in_n, other_busy;
  logic       breq_n, prio_out_n, busy_drive, cbrq_drive, aen_n;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  assign busy_in_n = ~(busy_drive | other_busy);

  mba_arbiter dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .stat(stat), .lock_n(lock_n),
    .crqlck_n(crqlck_n), .resb_strap(resb_strap), .iob_strap(iob_strap),
    .anyrq_strap(anyrq_strap), .sysmap(sysmap), .prio_in_n(prio_in_n),
    .busy_in_n(busy_in_n), .cbrq_in_n(cbrq_in_n), .breq_n(breq_n),
    .prio_out_n(prio_out_n), .busy_drive(busy_drive), .cbrq_drive(cbrq_drive),
    .aen_n(aen_n));

  function automatic bit need_f(logic [2:0] s, bit iob, bit resb, bit map);
    bit mem, io;
    mem = s[2] && (s != 3'b111);
    io  = !s[2] && (s != 3'b011);
    return (iob ? mem : (mem || io)) && (!resb || map);
  endfunction

  function automatic bit surr_f(logic [2:0] s, bit iob, bit resb, bit map,
                                bit lost, bit crq, bit lk_n, bit cl_n, bit any);
    bit nd, pas;
    nd  = need_f(s, iob, resb, map);
    pas = (s == 3'b111);
    if (!lk_n) return 1'b0;
    return (lost && !nd) || (crq && cl_n && (any ? !nd : (!nd && !pas)));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(bit own, string tag);
    check({tag, " breq_n"}, breq_n, own ? 0 : 1);
    check({tag, " aen_n"}, aen_n, own ? 0 : 1);
    check({tag, " busy_drive"}, busy_drive, own ? 1 : 0);
  endtask

  task automatic do_init();
    init_n = 1'b0;
    tick(1);
    init_n = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rise_c, fall_c;
    logic [2:0] s1, s2;
    bit iob, resb, map, lost, crq, lk, cl, any, nd, exp_keep;
    void'($urandom(32'd1234));
    rst_n = 1'b0; init_n = 1'b1; stat = 3'b111; lock_n = 1'b1; crqlck_n = 1'b1;
    resb_strap = 1'b0; iob_strap = 1'b0; anyrq_strap = 1'b0; sysmap = 1'b0;
    prio_in_n = 1'b1; cbrq_in_n = 1'b1; other_busy = 1'b0;
    tick(3);
    check("R1 reset breq_n", breq_n, 1);
    check("R1 reset aen_n", aen_n, 1);
    check("R1 reset busy_drive", busy_drive, 0);
    check("R1 reset cbrq_drive", cbrq_drive, 0);
    rst_n = 1'b1;
    tick(3);
    check("R5 no grant prio_out_n", prio_out_n, 1);
    prio_in_n = 1'b0;
    tick(1);
    check("R5 idle pass prio_out_n", prio_out_n, 0);

    // Another master holds busy: request but do not seize
    other_busy = 1'b1;
    stat = 3'b101;
    tick(6);
    check("R2 request breq_n", breq_n, 0);
    check("R4 waiting cbrq_drive", cbrq_drive, 1);
    check("R3 blocked aen_n", aen_n, 1);
    check("R5 requesting prio_out_n", prio_out_n, 1);
    other_busy = 1'b0;
    tick(6);
    expect_state(1'b1, "R3 seize");
    check("R4 holder cbrq_drive", cbrq_drive, 0);

    // Release order on lost priority
    stat = 3'b111;
    prio_in_n = 1'b1;
    rise_c = -1; fall_c = -1;
    for (int c = 0; c < 12; c++) begin
      tick(1);
      if (rise_c < 0 && aen_n) rise_c = c;
      if (fall_c < 0 && !busy_drive) fall_c = c;
    end
    check("R12 busy falls one clock after aen", fall_c - rise_c, 1);
    check("R6 released", busy_drive, 0);

    // Init during ownership
    prio_in_n = 1'b0;
    stat = 3'b110;
    tick(8);
    stat = 3'b111;
    tick(2);
    expect_state(1'b1, "R3 owned before init");
    do_init();
    expect_state(1'b0, "R1 init");
    check("R1 init cbrq_drive", cbrq_drive, 0);

    // Common request without any-request strap waits for a halt
    stat = 3'b100;
    tick(8);
    stat = 3'b111;
    cbrq_in_n = 1'b0;
    tick(8);
    expect_state(1'b1, "R9 passive keeps");
    stat = 3'b011;
    tick(8);
    expect_state(1'b0, "R9 halt surrender");
    cbrq_in_n = 1'b1;
    stat = 3'b111;
    tick(3);

    // Random sweep
    for (int it = 0; it < 400; it++) begin
      iob = $urandom_range(0, 1); resb = $urandom_range(0, 1);
      map = $urandom_range(0, 1); any = $urandom_range(0, 1);
      s1 = 3'($urandom_range(0, 7)); s2 = 3'($urandom_range(0, 7));
      lost = $urandom_range(0, 1); crq = $urandom_range(0, 1);
      lk = ($urandom_range(0, 3) != 0); cl = ($urandom_range(0, 2) != 0);
      stat = 3'b111; prio_in_n = 1'b0; cbrq_in_n = 1'b1;
      lock_n = 1'b1; crqlck_n = 1'b1;
      iob_strap = iob; resb_strap = resb; sysmap = map; anyrq_strap = any;
      do_init();
      stat = s1;
      tick(8);
      nd = need_f(s1, iob, resb, map);
      expect_state(nd, "R2 R10 R11 need");
      if (!nd) check("R5 idle prio_out_n", prio_out_n, 0);
      if (nd) begin
        stat = s2; prio_in_n = lost; cbrq_in_n = !crq;
        lock_n = lk; crqlck_n = cl;
        tick(8);
        exp_keep = !surr_f(s2, iob, resb, map, lost, crq, lk, cl, any);
        expect_state(exp_keep, "R6 R7 R8 R9 surrender");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule